// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Master

This block is a serial master for a frame-pulse synchronous link. On its local side it reads words from a transmit FIFO through a data, available and pop interface. It returns received words to a receive FIFO through a data and push interface. On the serial side it drives a serial clock, a frame pulse, and a transmit data line with an output-enable. It samples a receive data line.

The block stays quiet while the transmit FIFO is empty. When a word appears, the block raises the frame output for one serial clock period and takes the word in during that period. It then shifts the word out MSB-first, one bit per serial clock rising edge. At the same time it collects the incoming bits on the falling edges. If another word is waiting when the last bit of the current word goes out, the next frame pulse overlaps that last bit period, so words follow with no gap. The word length can be set from 4 to 16 bits. The serial clock comes from an even division of the system clock.

Top module: `fps_master`

## Requirements
- R1: After reset and whenever no transfer is active, `sclk_o` and `frame_o` are low. A transfer starts when `tx_avail_i` is high, and the first serial rising edge follows after one half-period of low clock.
- R2: `txd_oe_o` is low and `txd_o` is 0 whenever no data bit is being driven. `txd_oe_o` rises with the rising edge that drives a word's MSB and stays high through the last bit period of the last back-to-back word.
- R3: The frame pulse starts on a serial rising edge and lasts exactly one serial clock period. `tx_pop_o` is high for one system cycle, in the cycle whose clock edge starts that pulse, and `tx_data_i` is captured at that edge.
- R4: On the rising edge that ends the frame pulse, the MSB of the captured word is driven. The remaining bits follow MSB-first, one per rising edge, for as many bits as the word length.
- R5: `rxd_i` is sampled on every serial falling edge that lies inside a word's data bit periods, and never during a frame pulse that is not overlapping data.
- R6: `word_len_i` gives the number of bits per word and is captured at the pop. A value below 4 is treated as 4, and a value above 16 is treated as 16.
- R7: `rx_push_o` pulses for one system cycle just after the first serial rising-edge time that follows the LSB sample. `rx_data_o` holds the received word right-justified, with the first sampled bit as its MSB and the unused upper bits zero.
- R8: If `tx_avail_i` is high at the rising edge that drives the LSB, the next frame pulse covers the LSB period. The next MSB follows on the next rising edge. n back-to-back words of L bits therefore take (1+n*L) serial periods from the first pop to the last push.
- R9: If no word is available at the rising edge that drives the LSB, then at the end of the LSB period the clock stays low, `txd_oe_o` falls and `txd_o` returns to 0.
- R10: Each half-period of `sclk_o` lasts max(`div_half_i`,1) system clock cycles, so the divide ratio is even and at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_half_i | input | DIV_W | Serial half-period in system cycles (0 acts as 1) |
| word_len_i | input | LEN_W | Bits per word, 4 to 16 |
| tx_data_i | input | DATA_W | Transmit FIFO head word, right-justified |
| tx_avail_i | input | 1 | Transmit FIFO holds a word |
| tx_pop_o | output | 1 | Take the head word from the transmit FIFO |
| rx_data_o | output | DATA_W | Received word, right-justified |
| rx_push_o | output | 1 | Write `rx_data_o` to the receive FIFO |
| sclk_o | output | 1 | Serial clock |
| frame_o | output | 1 | Frame pulse |
| txd_o | output | 1 | Transmit data |
| txd_oe_o | output | 1 | Transmit data output-enable (pad drives when high) |
| rxd_i | input | 1 | Receive data |

## Verification
The bound checker watches several edge relations on every cycle:
- a quiet link keeps the clock low;
- the data line stays at zero while its enable is off;
- a frame pulse starts and ends on a serial rising edge;
- a pop is followed by a fresh rising edge with the frame high;
- the data line and the receive push move only on a rising edge or at the release of the line.

The exact lengths of the half-periods, the bit order, the received word values, the length clamping and the gapless back-to-back timing can only be shown by the bench. Its cycle-level reference model tracks the queue of words and the bit streams under several divider and length settings.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_DATA  = 2'd2
  } fps_state_e;

  localparam int unsigned FPS_MIN_LEN = 4;
endpackage

// File: rtl/fps_clkgen.sv
module fps_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] half_i,
  input  logic             run_i,
  input  logic             park_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, half_eff;
  logic             sclk_q, due;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  assign due      = (cnt_q == half_eff - DIV_W'(1));
  assign rise_o   = run_i & ~sclk_q & due;
  assign fall_o   = run_i &  sclk_q & due;
  assign sclk_o   = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (due) begin
      cnt_q  <= '0;
      // a parked rising edge keeps the clock low while the link drops to idle
      sclk_q <= (rise_o && park_i) ? 1'b0 : ~sclk_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/fps_tx_shift.sv
module fps_tx_shift #(
  parameter int DATA_W = 16,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              shift_i,
  input  logic              clr_i,
  output logic              txd_o
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic              txd_q;

  assign txd_o = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      txd_q <= 1'b0;
    end else begin
      if (shift_i)    txd_q <= sh_q[DATA_W-1];
      else if (clr_i) txd_q <= 1'b0;
      // load wins: the LSB edge of a word may also take the next word
      if (load_i)       sh_q <= data_i << (FULL - len_i);
      else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/fps_rx_shift.sv
module fps_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              rxd_i,
  input  logic              push_i,
  output logic [DATA_W-1:0] data_o,
  output logic              push_o
);
  logic [DATA_W-1:0] sh_q, data_q;
  logic              push_q;

  assign data_o = data_q;
  assign push_o = push_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      data_q <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= push_i;
      if (push_i) data_q <= sh_q;
      if (clr_i)       sh_q <= '0;
      else if (take_i) sh_q <= {sh_q[DATA_W-2:0], rxd_i};
    end
  end
endmodule

// File: rtl/fps_master.sv
module fps_master
  import fps_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_half_i,
  input  logic [LEN_W-1:0]  word_len_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_avail_i,
  output logic              tx_pop_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_push_o,
  output logic              sclk_o,
  output logic              frame_o,
  output logic              txd_o,
  output logic              txd_oe_o,
  input  logic              rxd_i
);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(FPS_MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(DATA_W);
  localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);

  fps_state_e       state_q;
  logic [LEN_W-1:0] left_q, len_q, len_eff;
  logic             pend_q, frame_q, oe_q;
  logic             run, park, rise, fall;
  logic             load, shift, tx_clr, rx_clr, push, rx_take;

  assign len_eff = (word_len_i < LEN_LO) ? LEN_LO :
                   (word_len_i > LEN_HI) ? LEN_HI : word_len_i;

  assign run  = (state_q != ST_IDLE) | tx_avail_i;
  assign park = (state_q == ST_DATA) && (left_q == '0) && !pend_q;

  fps_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .half_i (div_half_i),
    .run_i  (run),
    .park_i (park),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    load   = 1'b0;
    shift  = 1'b0;
    tx_clr = 1'b0;
    rx_clr = 1'b0;
    push   = 1'b0;
    if (rise) begin
      unique case (state_q)
        ST_IDLE:  load = tx_avail_i;
        ST_FRAME: begin
          shift  = 1'b1;
          rx_clr = 1'b1;
        end
        ST_DATA: begin
          if (left_q != '0) begin
            shift = 1'b1;
            load  = (left_q == ONE) & tx_avail_i;
          end else begin
            push = 1'b1;
            if (pend_q) begin
              shift  = 1'b1;
              rx_clr = 1'b1;
            end else begin
              tx_clr = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rx_take  = fall & (state_q == ST_DATA);
  assign tx_pop_o = load;
  assign frame_o  = frame_q;
  assign txd_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      len_q   <= LEN_LO;
      pend_q  <= 1'b0;
      frame_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (rise) begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_FRAME;
          frame_q <= 1'b1;
          len_q   <= len_eff;
        end
        ST_FRAME: begin
          state_q <= ST_DATA;
          frame_q <= 1'b0;
          oe_q    <= 1'b1;
          left_q  <= len_q - ONE;
        end
        ST_DATA: begin
          if (left_q != '0) begin
            left_q <= left_q - ONE;
            if (load) begin
              frame_q <= 1'b1;
              pend_q  <= 1'b1;
              len_q   <= len_eff;
            end
          end else if (pend_q) begin
            frame_q <= 1'b0;
            pend_q  <= 1'b0;
            left_q  <= len_q - ONE;
          end else begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fps_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (tx_data_i),
    .len_i   (len_eff),
    .shift_i (shift),
    .clr_i   (tx_clr),
    .txd_o   (txd_o)
  );

  fps_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rx_clr),
    .take_i (rx_take),
    .rxd_i  (rxd_i),
    .push_i (push),
    .data_o (rx_data_o),
    .push_o (rx_push_o)
  );
endmodule

// File: rtl/fps_master_chk.sv
module fps_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_pop_o,
  input logic rx_push_o,
  input logic sclk_o,
  input logic frame_o,
  input logic txd_o,
  input logic txd_oe_o
);
  a_r1_quiet_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txd_oe_o && !frame_o) |-> !sclk_o);

  a_r2_line_zero_when_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_oe_o |-> !txd_o);

  a_r2_enable_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txd_oe_o) |-> $rose(sclk_o));

  a_r3_frame_starts_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> $rose(sclk_o));

  a_r3_frame_ends_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_o) |-> $rose(sclk_o));

  a_r3_pop_opens_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |=> ($rose(sclk_o) && frame_o));

  a_r4_txd_moves_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> ($rose(sclk_o) || $fell(txd_oe_o)));

  a_r7_push_on_rise_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> ($rose(sclk_o) || $fell(txd_oe_o)));

  a_r9_release_keeps_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txd_oe_o) |-> (!sclk_o && !frame_o));
endmodule

bind fps_master fps_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_pop_o  (tx_pop_o),
  .rx_push_o (rx_push_o),
  .sclk_o    (sclk_o),
  .frame_o   (frame_o),
  .txd_o     (txd_o),
  .txd_oe_o  (txd_oe_o)
);

// File: tb/fps_master_bench.sv
module fps_master_bench;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = $clog2(DATA_W + 1);
  localparam int WDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  div_half = 8'd2;
  logic [LEN_W-1:0]  word_len = 5'd8;
  logic [DATA_W-1:0] tx_data = '0;
  logic              tx_avail = 1'b0;
  logic              tx_pop;
  logic [DATA_W-1:0] rx_data;
  logic              rx_push;
  logic              sclk, frame, txd, txd_oe;
  logic              rxd = 1'b0;

  always #2.5 clk = ~clk;

  fps_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_fps_master (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .div_half_i (div_half),
    .word_len_i (word_len),
    .tx_data_i  (tx_data),
    .tx_avail_i (tx_avail),
    .tx_pop_o   (tx_pop),
    .rx_data_o  (rx_data),
    .rx_push_o  (rx_push),
    .sclk_o     (sclk),
    .frame_o    (frame),
    .txd_o      (txd),
    .txd_oe_o   (txd_oe),
    .rxd_i      (rxd)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] lfsr = 16'hACE1;

  // bench FIFO and reference model
  int q[$];
  bit pop_pend = 0;
  int m_state = 0, m_cnt = 0, m_left = 0, m_len = 0, rx_acc = 0;
  bit m_sclk = 0, m_pend = 0;
  bit cur_bits[$];
  bit nxt_bits[$];
  bit e_sclk = 0, e_frame = 0, e_oe = 0, e_txd = 0, e_push = 0;
  int e_rx = 0;
  int t_pop_first = -1, t_push_last = -1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int eff_len(input int l);
    if (l < 4) return 4;
    if (l > 16) return 16;
    return l;
  endfunction

  task automatic load_word();
    nxt_bits.delete();
    m_len = eff_len(int'(word_len));
    for (int i = m_len - 1; i >= 0; i--) nxt_bits.push_back(q[0][i]);
  endtask

  task automatic step();
    bit valid, park, run, due, rise, fall, exp_pop;
    int hh, old_left;
    @(negedge clk);
    cyc++;
    if (cyc > WDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      finish_run();
    end
    if (pop_pend && q.size() != 0) void'(q.pop_front());
    pop_pend = 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rxd = lfsr[0];
    tx_avail = (q.size() != 0);
    tx_data = (q.size() != 0) ? DATA_W'(q[0]) : '0;
    #1;
    // outputs registered at the previous edge
    chk(sclk == e_sclk, "R10 sclk", sclk, e_sclk);
    chk(frame == e_frame, "R3 frame", frame, e_frame);
    chk(txd_oe == e_oe, "R2 oe", txd_oe, e_oe);
    chk(txd == e_txd, "R4 txd", txd, e_txd);
    chk(rx_push == e_push, "R7 push", rx_push, e_push);
    if (rx_push && e_push) chk(rx_data == DATA_W'(e_rx), "R5 rx word", rx_data, e_rx);
    if (rx_push) t_push_last = cyc;
    // model of the coming edge
    hh = (div_half == 0) ? 1 : int'(div_half);
    valid = (q.size() != 0);
    park = (m_state == 2) && (m_left == 0) && !m_pend;
    run = (m_state != 0) || valid;
    due = (m_cnt == hh - 1);
    rise = run && !m_sclk && due;
    fall = run && m_sclk && due;
    exp_pop = rise && valid && ((m_state == 0) || (m_state == 2 && m_left == 1));
    chk(tx_pop == exp_pop, "R3 pop", tx_pop, exp_pop);
    if (tx_pop) begin
      pop_pend = 1;
      if (t_pop_first < 0) t_pop_first = cyc;
    end
    e_push = 0;
    if (fall && m_state == 2) rx_acc = ((rx_acc << 1) | int'(rxd)) & 32'hFFFF;
    if (rise) begin
      case (m_state)
        0: begin
          load_word();
          e_frame = 1;
          m_state = 1;
        end
        1: begin
          cur_bits = nxt_bits;
          e_txd = cur_bits.pop_front();
          e_frame = 0;
          e_oe = 1;
          m_left = m_len - 1;
          rx_acc = 0;
          m_state = 2;
        end
        default: begin
          if (m_left != 0) begin
            old_left = m_left;
            e_txd = cur_bits.pop_front();
            m_left--;
            if (old_left == 1 && valid) begin
              load_word();
              e_frame = 1;
              m_pend = 1;
            end
          end else begin
            e_push = 1;
            e_rx = rx_acc;
            if (m_pend) begin
              cur_bits = nxt_bits;
              e_txd = cur_bits.pop_front();
              e_frame = 0;
              m_pend = 0;
              m_left = m_len - 1;
              rx_acc = 0;
            end else begin
              m_state = 0;
              e_oe = 0;
              e_txd = 0;
            end
          end
        end
      endcase
    end
    if (!run) begin
      m_cnt = 0;
      m_sclk = 0;
    end else if (due) begin
      m_cnt = 0;
      m_sclk = (rise && park) ? 1'b0 : !m_sclk;
    end else begin
      m_cnt++;
    end
    e_sclk = m_sclk;
  endtask

  task automatic drain();
    while (q.size() != 0 || m_state != 0) step();
    for (int i = 0; i < 4; i++) step();
    chk(!sclk && !frame && !txd_oe && !txd, "R9 idle after last word",
        {sclk, frame, txd_oe, txd}, 0);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    chk(!sclk && !frame && !txd_oe && !txd && !tx_pop && !rx_push, "R1 reset state",
        {sclk, frame, txd_oe, txd, tx_pop, rx_push}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step();
    chk(!sclk && !frame, "R1 quiet with empty FIFO", {sclk, frame}, 0);

    // single 8-bit word, ratio 4
    div_half = 8'd2; word_len = 5'd8;
    q.push_back(16'h00A5);
    drain();

    // three back-to-back 16-bit words, ratio 2
    div_half = 8'd1; word_len = 5'd16;
    t_pop_first = -1; t_push_last = -1;
    q.push_back(16'hC3F0); q.push_back(16'h1234); q.push_back(16'hFFFF);
    drain();
    chk(t_push_last - t_pop_first == (1 + 3 * 16) * 2 + 1, "R8 gapless span",
        t_push_last - t_pop_first, (1 + 3 * 16) * 2 + 1);

    // 4-bit words separated by an idle gap, ratio 6
    div_half = 8'd3; word_len = 5'd4;
    q.push_back(16'h0009);
    drain();
    for (int i = 0; i < 7; i++) step();
    q.push_back(16'h0006);
    drain();

    // length clamping and zero divider
    div_half = 8'd0; word_len = 5'd2;
    q.push_back(16'h000B);
    drain();
    word_len = 5'd25;
    t_pop_first = -1; t_push_last = -1;
    q.push_back(16'h8001);
    drain();
    chk(t_push_last - t_pop_first == (1 + 16) * 2 + 1, "R6 clamp to 16 bits",
        t_push_last - t_pop_first, (1 + 16) * 2 + 1);

    // back-to-back words with a length change between them
    div_half = 8'd2; word_len = 5'd12;
    q.push_back(16'h0ABC); q.push_back(16'h005A);
    step();
    word_len = 5'd7;
    drain();

    finish_run();
  end
endmodule